// File: doc/BRIEF.md
# Raster LCD Timing Generator

This block produces the raster timing for an LCD panel: a pixel clock enable, a line sync, a frame sync, a data-enable strobe and the zero-based column and row of the pixel being shown. It derives the pixel rate from the system clock through a programmable divider. A bypass setting makes every system clock cycle a pixel. The pixel fetch path uses the data-enable, column and row outputs to decide which pixel to present, and the sync outputs drive the panel directly.

All timing settings arrive as plain input ports. Sync widths, porches, active size, sync polarities, panel type, divider value and bypass are copied into shadow registers only when a frame begins, so software may rewrite them at any moment. A line runs sync, back porch, active pixels, front porch, and a frame runs the same four phases counted in lines. The horizontal fields and the vertical sync width hold their count minus one. The vertical porches hold their count as is, and zero is a legal value.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `enable` is low, `dataEn`, `pixClkEn`, `col` and `row` are 0, `lineSync` equals `cfgLineInv` and `frameSync` equals `cfgFrameInv`.
- R2: With bypass set, `pixClkEn` is high on every cycle of a frame. With bypass clear and divider value N, it is high for one cycle in every 2(N+1), and the first pulse of a frame falls on that frame's 2(N+1)th cycle.
- R3: Each line is cfgHsw+1 pixels of line sync, then cfgHbp+1 back porch pixels, then cfgHact+1 active pixels, then cfgHfp+1 front porch pixels. The line sync is never active while `dataEn` is high.
- R4: Each frame is cfgVsw+1 lines of frame sync, then cfgVbp back porch lines, then cfgVact+1 active lines, then cfgVfp front porch lines. Either porch may be zero lines.
- R5: With the TFT bit set, `dataEn` is high exactly when both the column and the row are inside the active area. There `col` and `row` count from 0, and `col` steps by one on each pixel along an active line. Outside the area both are 0.
- R6: A polarity bit of 0 makes its sync output high while the sync is active. A polarity bit of 1 makes it low while active.
- R7: With the TFT bit clear (passive panel), `dataEn` stays low and `col` and `row` are still reported inside the active area.
- R8: Every timing input, including divider, bypass, polarities and panel type, is taken up only when a frame begins. A change made mid-frame first appears in the next frame.
- R9: On the first cycle after `enable` is sampled high, the position is the first line sync pixel of a new frame, using the settings present at that edge. The outputs `col`, `row` and `dataEn` change only after a cycle with `pixClkEn` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the timing generator |
| cfgHsw | input | TIM_W | Line sync width minus one |
| cfgHbp | input | TIM_W | Horizontal back porch minus one |
| cfgHfp | input | TIM_W | Horizontal front porch minus one |
| cfgHact | input | H_W | Active pixels per line minus one |
| cfgVsw | input | TIM_W | Frame sync width in lines minus one |
| cfgVbp | input | TIM_W | Vertical back porch lines |
| cfgVfp | input | TIM_W | Vertical front porch lines |
| cfgVact | input | V_W | Active lines minus one |
| cfgLineInv | input | 1 | 1 = line sync active low |
| cfgFrameInv | input | 1 | 1 = frame sync active low |
| cfgPanelTft | input | 1 | 1 = TFT panel, 0 = passive panel |
| cfgClkDiv | input | DIV_W | Divider N, pixel rate = clk / 2(N+1) |
| cfgBypass | input | 1 | 1 = pixel rate equals clk |
| pixClkEn | output | 1 | One-cycle pixel tick |
| lineSync | output | 1 | Line sync with polarity applied |
| frameSync | output | 1 | Frame sync with polarity applied |
| dataEn | output | 1 | Active pixel strobe |
| col | output | H_W | Column inside the active area |
| row | output | V_W | Row inside the active area |

## Verification
The assertions check on every cycle that the block is quiet while disabled and that back-to-back pixel ticks occur only in a bypass frame. They also check that position outputs hold between ticks, that the column steps by one along an active line, that no data-enable appears in a passive frame, and that both syncs sit at their inactive levels while data-enable is high. Only the bench scenarios can show the exact phase lengths of lines and frames, including zero-line porches. The same goes for the placement of the divided tick, the restart position after enable, and the deferral of a mid-frame rewrite to the next frame boundary. The bench checks these by comparing every cycle against positions computed from the settings.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } runState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic active;  // generator running this cycle
    logic load;    // frame begins at this edge: sample settings, zero counters
    logic tick;    // pixel advance at this edge
  } strobe_t;

  function automatic logic applyPol(logic isActive, logic inv);
    return isActive ^ inv;
  endfunction

endpackage

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
  import lcd_timing_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfgClkDiv,
  input  logic             cfgBypass,
  input  logic             frameLast,
  output strobe_t          strobe,
  output logic             frameBypass
);

  localparam int CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  runState_e        state;
  logic [DIV_W-1:0] divS;
  logic             bypassS;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLim;
  logic             running;
  logic             tick;
  logic             load;

  // 2(N+1) cycles per pixel: count 0 .. 2N+1
  assign divLim  = {divS, 1'b1};
  assign running = (state == ST_RUN) && enable;
  assign tick    = running && (bypassS || (divCnt == divLim));
  assign load    = enable && ((state == ST_IDLE) || (tick && frameLast));

  assign strobe.active = running;
  assign strobe.load   = load;
  assign strobe.tick   = tick;
  assign frameBypass   = bypassS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divS    <= '0;
      bypassS <= 1'b0;
      divCnt  <= '0;
    end else if (!enable) begin
      state  <= ST_IDLE;
      divCnt <= '0;
    end else begin
      state <= ST_RUN;
      if (load) begin
        divS    <= cfgClkDiv;
        bypassS <= cfgBypass;
        divCnt  <= '0;
      end else if (running) begin
        divCnt <= (divCnt >= divLim) ? '0 : divCnt + CNT_ONE;
      end
    end
  end

endmodule

// File: rtl/lcd_timing_dp.sv
module lcd_timing_dp
  import lcd_timing_pkg::*;
#(
  parameter int TIM_W = 8,
  parameter int H_W   = 10,
  parameter int V_W   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [TIM_W-1:0] cfgHsw,
  input  logic [TIM_W-1:0] cfgHbp,
  input  logic [TIM_W-1:0] cfgHfp,
  input  logic [H_W-1:0]   cfgHact,
  input  logic [TIM_W-1:0] cfgVsw,
  input  logic [TIM_W-1:0] cfgVbp,
  input  logic [TIM_W-1:0] cfgVfp,
  input  logic [V_W-1:0]   cfgVact,
  input  logic             cfgLineInv,
  input  logic             cfgFrameInv,
  input  logic             cfgPanelTft,
  output logic             frameLast,
  output logic             lineSync,
  output logic             frameSync,
  output logic             dataEn,
  output logic [H_W-1:0]   col,
  output logic [V_W-1:0]   row,
  output logic             frameTft,
  output logic             frameLineInv,
  output logic             frameFrameInv
);

  localparam int HC_W = ((H_W > TIM_W) ? H_W : TIM_W) + 2;
  localparam int VC_W = ((V_W > TIM_W) ? V_W : TIM_W) + 2;
  localparam logic [HC_W-1:0] H_ONE = HC_W'(1);
  localparam logic [VC_W-1:0] V_ONE = VC_W'(1);

  // frame shadow of the settings
  logic [TIM_W-1:0] hswS, hbpS, hfpS, vswS, vbpS, vfpS;
  logic [H_W-1:0]   hactS;
  logic [V_W-1:0]   vactS;
  logic             tftS, lInvS, fInvS;

  logic [HC_W-1:0] hCnt;
  logic [VC_W-1:0] vCnt;

  logic [HC_W-1:0] hSyncEnd, hActStart, hActEnd, hLast;
  logic [VC_W-1:0] vSyncEnd, vActStart, vActEnd, vLast;
  logic            inH, inV, inArea, lineEnd;

  // phase boundaries, mixed encodings resolved here
  assign hSyncEnd  = HC_W'(hswS) + H_ONE;
  assign hActStart = hSyncEnd + HC_W'(hbpS) + H_ONE;
  assign hActEnd   = hActStart + HC_W'(hactS) + H_ONE;
  assign hLast     = hActEnd + HC_W'(hfpS);

  assign vSyncEnd  = VC_W'(vswS) + V_ONE;
  assign vActStart = vSyncEnd + VC_W'(vbpS);
  assign vActEnd   = vActStart + VC_W'(vactS) + V_ONE;
  assign vLast     = vActEnd + VC_W'(vfpS) - V_ONE;

  assign lineEnd   = (hCnt == hLast);
  assign frameLast = lineEnd && (vCnt == vLast);

  assign inH    = (hCnt >= hActStart) && (hCnt < hActEnd);
  assign inV    = (vCnt >= vActStart) && (vCnt < vActEnd);
  assign inArea = strobe.active && inH && inV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt  <= '0;
      vCnt  <= '0;
      hswS  <= '0;
      hbpS  <= '0;
      hfpS  <= '0;
      hactS <= '0;
      vswS  <= '0;
      vbpS  <= '0;
      vfpS  <= '0;
      vactS <= '0;
      tftS  <= 1'b0;
      lInvS <= 1'b0;
      fInvS <= 1'b0;
    end else if (strobe.load) begin
      hCnt  <= '0;
      vCnt  <= '0;
      hswS  <= cfgHsw;
      hbpS  <= cfgHbp;
      hfpS  <= cfgHfp;
      hactS <= cfgHact;
      vswS  <= cfgVsw;
      vbpS  <= cfgVbp;
      vfpS  <= cfgVfp;
      vactS <= cfgVact;
      tftS  <= cfgPanelTft;
      lInvS <= cfgLineInv;
      fInvS <= cfgFrameInv;
    end else if (!strobe.active) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strobe.tick) begin
      if (lineEnd) begin
        hCnt <= '0;
        vCnt <= (vCnt == vLast) ? '0 : vCnt + V_ONE;
      end else begin
        hCnt <= hCnt + H_ONE;
      end
    end
  end

  assign lineSync  = applyPol(strobe.active && (hCnt < hSyncEnd),
                              strobe.active ? lInvS : cfgLineInv);
  assign frameSync = applyPol(strobe.active && (vCnt < vSyncEnd),
                              strobe.active ? fInvS : cfgFrameInv);
  assign dataEn    = inArea && tftS;
  assign col       = inArea ? H_W'(hCnt - hActStart) : '0;
  assign row       = inArea ? V_W'(vCnt - vActStart) : '0;

  assign frameTft      = tftS;
  assign frameLineInv  = lInvS;
  assign frameFrameInv = fInvS;

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter int TIM_W = 8,
  parameter int H_W   = 10,
  parameter int V_W   = 10,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [TIM_W-1:0] cfgHsw,
  input  logic [TIM_W-1:0] cfgHbp,
  input  logic [TIM_W-1:0] cfgHfp,
  input  logic [H_W-1:0]   cfgHact,
  input  logic [TIM_W-1:0] cfgVsw,
  input  logic [TIM_W-1:0] cfgVbp,
  input  logic [TIM_W-1:0] cfgVfp,
  input  logic [V_W-1:0]   cfgVact,
  input  logic             cfgLineInv,
  input  logic             cfgFrameInv,
  input  logic             cfgPanelTft,
  input  logic [DIV_W-1:0] cfgClkDiv,
  input  logic             cfgBypass,
  output logic             pixClkEn,
  output logic             lineSync,
  output logic             frameSync,
  output logic             dataEn,
  output logic [H_W-1:0]   col,
  output logic [V_W-1:0]   row
);

  strobe_t strobe;
  logic    frameLast;
  logic    frameBypass;
  logic    frameTft;
  logic    frameLineInv;
  logic    frameFrameInv;

  lcd_timing_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .cfgClkDiv  (cfgClkDiv),
    .cfgBypass  (cfgBypass),
    .frameLast  (frameLast),
    .strobe     (strobe),
    .frameBypass(frameBypass)
  );

  lcd_timing_dp #(.TIM_W(TIM_W), .H_W(H_W), .V_W(V_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgHsw       (cfgHsw),
    .cfgHbp       (cfgHbp),
    .cfgHfp       (cfgHfp),
    .cfgHact      (cfgHact),
    .cfgVsw       (cfgVsw),
    .cfgVbp       (cfgVbp),
    .cfgVfp       (cfgVfp),
    .cfgVact      (cfgVact),
    .cfgLineInv   (cfgLineInv),
    .cfgFrameInv  (cfgFrameInv),
    .cfgPanelTft  (cfgPanelTft),
    .frameLast    (frameLast),
    .lineSync     (lineSync),
    .frameSync    (frameSync),
    .dataEn       (dataEn),
    .col          (col),
    .row          (row),
    .frameTft     (frameTft),
    .frameLineInv (frameLineInv),
    .frameFrameInv(frameFrameInv)
  );

  assign pixClkEn = strobe.tick;

endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk #(
  parameter int H_W = 10,
  parameter int V_W = 10
) (
  input logic           clk,
  input logic           rstN,
  input logic           enable,
  input logic           pixClkEn,
  input logic           lineSync,
  input logic           frameSync,
  input logic           dataEn,
  input logic [H_W-1:0] col,
  input logic [V_W-1:0] row,
  input logic           frameBypass,
  input logic           frameTft,
  input logic           frameLineInv,
  input logic           frameFrameInv
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!dataEn && !pixClkEn && col == '0 && row == '0));

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && pixClkEn && $past(pixClkEn)) |-> frameBypass);

  p_sync_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> (lineSync == frameLineInv && frameSync == frameFrameInv));

  p_col_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && dataEn && $past(dataEn) && $past(pixClkEn))
      |-> (col == $past(col) + 1'b1));

  p_passive_no_de_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> frameTft);

  p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$past(pixClkEn))
      |-> ($stable(col) && $stable(row) && $stable(dataEn)));

endmodule

bind lcd_timing_gen lcd_timing_chk #(.H_W(H_W), .V_W(V_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .pixClkEn     (pixClkEn),
  .lineSync     (lineSync),
  .frameSync    (frameSync),
  .dataEn       (dataEn),
  .col          (col),
  .row          (row),
  .frameBypass  (frameBypass),
  .frameTft     (frameTft),
  .frameLineInv (frameLineInv),
  .frameFrameInv(frameFrameInv)
);

// File: tb/lcd_timing_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb_top;

  localparam int TIM_W = 8;
  localparam int H_W   = 10;
  localparam int V_W   = 10;
  localparam int DIV_W = 8;

  typedef struct {
    int hsw, hbp, hact, hfp;
    int vsw, vbp, vact, vfp;
    int div;
    bit byp, tft, linv, finv;
  } cfg_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  cfg_t live;
  cfg_t cur;

  logic             pixClkEn, lineSync, frameSync, dataEn;
  logic [H_W-1:0]   col;
  logic [V_W-1:0]   row;

  int totalCnt = 0;
  int failCnt  = 0;
  int k        = 0;
  int fStart   = 0;
  bit done     = 0;
  string scen  = "R1 reset";

  always #2.5 clk = ~clk;

  lcd_timing_gen #(.TIM_W(TIM_W), .H_W(H_W), .V_W(V_W), .DIV_W(DIV_W)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .cfgHsw     (TIM_W'(live.hsw)),
    .cfgHbp     (TIM_W'(live.hbp)),
    .cfgHfp     (TIM_W'(live.hfp)),
    .cfgHact    (H_W'(live.hact)),
    .cfgVsw     (TIM_W'(live.vsw)),
    .cfgVbp     (TIM_W'(live.vbp)),
    .cfgVfp     (TIM_W'(live.vfp)),
    .cfgVact    (V_W'(live.vact)),
    .cfgLineInv (live.linv),
    .cfgFrameInv(live.finv),
    .cfgPanelTft(live.tft),
    .cfgClkDiv  (DIV_W'(live.div)),
    .cfgBypass  (live.byp),
    .pixClkEn   (pixClkEn),
    .lineSync   (lineSync),
    .frameSync  (frameSync),
    .dataEn     (dataEn),
    .col        (col),
    .row        (row)
  );

  task automatic chk(string tag, string what, int act, int exp);
    totalCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s [%s] %s at k=%0d: actual %0d expected %0d",
               tag, scen, what, k, act, exp);
    end
  endtask

  function automatic int divOf(cfg_t c);
    return c.byp ? 1 : 2 * (c.div + 1);
  endfunction

  function automatic int hTotOf(cfg_t c);
    return c.hsw + c.hbp + c.hact + c.hfp + 4;
  endfunction

  function automatic int vTotOf(cfg_t c);
    return c.vsw + 1 + c.vbp + c.vact + 1 + c.vfp;
  endfunction

  // R1: quiet outputs while disabled
  task automatic checkIdle();
    chk("R1", "pixClkEn", int'(pixClkEn), 0);
    chk("R1", "dataEn", int'(dataEn), 0);
    chk("R1", "col", int'(col), 0);
    chk("R1", "row", int'(row), 0);
    chk("R1", "lineSync", int'(lineSync), int'(live.linv));
    chk("R1", "frameSync", int'(frameSync), int'(live.finv));
  endtask

  task automatic checkRun();
    int d, rel, p, ht, hc, vc, hs, has, hae, vs, vas, vae;
    bit inA;
    d   = divOf(cur);
    rel = k - fStart;
    if (rel == hTotOf(cur) * vTotOf(cur) * d) begin
      fStart = k;
      cur    = live;
      d      = divOf(cur);
      rel    = 0;
    end
    p   = rel / d;
    ht  = hTotOf(cur);
    hc  = p % ht;
    vc  = p / ht;
    hs  = cur.hsw + 1;
    has = hs + cur.hbp + 1;
    hae = has + cur.hact + 1;
    vs  = cur.vsw + 1;
    vas = vs + cur.vbp;
    vae = vas + cur.vact + 1;
    inA = (hc >= has) && (hc < hae) && (vc >= vas) && (vc < vae);
    chk("R2", "pixClkEn", int'(pixClkEn), int'((rel % d) == (d - 1)));
    chk("R3", "lineSync", int'(lineSync), int'((hc < hs) ^ cur.linv));
    chk("R4", "frameSync", int'(frameSync), int'((vc < vs) ^ cur.finv));
    if (cur.tft) chk("R5", "dataEn", int'(dataEn), int'(inA));
    else         chk("R7", "dataEn", int'(dataEn), 0);
    chk("R5", "col", int'(col), inA ? hc - has : 0);
    chk("R5", "row", int'(row), inA ? vc - vas : 0);
  endtask

  task automatic startRun();
    @(negedge clk);
    enable = 1'b1;
    k      = -1;
    fStart = 0;
    cur    = live;
  endtask

  task automatic stepRun(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      checkRun();
    end
  endtask

  task automatic stepIdle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      checkIdle();
    end
  endtask

  task automatic stopRun();
    enable = 1'b0;
  endtask

  cfg_t cfgA, cfgB, cfgC, cfgD;

  initial begin
    cfgA = '{hsw:0, hbp:0, hact:3, hfp:0, vsw:0, vbp:0, vact:2, vfp:0,
             div:0, byp:1, tft:1, linv:0, finv:0};
    cfgB = '{hsw:1, hbp:1, hact:2, hfp:1, vsw:1, vbp:1, vact:1, vfp:2,
             div:1, byp:0, tft:1, linv:1, finv:1};
    cfgC = '{hsw:0, hbp:2, hact:4, hfp:1, vsw:2, vbp:2, vact:1, vfp:1,
             div:0, byp:0, tft:0, linv:0, finv:1};
    cfgD = '{hsw:0, hbp:0, hact:3, hfp:0, vsw:0, vbp:0, vact:2, vfp:0,
             div:0, byp:0, tft:1, linv:0, finv:0};
    live = cfgA;

    // reset, disabled
    repeat (3) @(negedge clk);
    checkIdle();
    rstN = 1'b1;
    stepIdle(3);
    scen = "R1 R6 idle inverted";
    live.linv = 1'b1;
    live.finv = 1'b1;
    stepIdle(2);

    // bypass, zero vertical porches
    live = cfgA;
    scen = "R9 bypass start";
    startRun();
    stepRun(2 * 28 + 5);
    stopRun();
    stepIdle(2);

    // divided by 4, inverted syncs, nonzero porches
    live = cfgB;
    scen = "R6 inverted div4";
    startRun();
    stepRun(2 * 63 * 4 + 3);
    stopRun();
    stepIdle(2);

    // passive panel, divided by 2
    live = cfgC;
    scen = "R7 passive div2";
    startRun();
    stepRun(2 * 88 * 2 + 3);

    // disable mid-frame then restart
    scen = "R1 mid-frame stop";
    stopRun();
    stepIdle(3);
    live = cfgA;
    scen = "R9 restart";
    startRun();
    stepRun(10);
    stopRun();
    stepIdle(1);

    // mid-frame rewrite takes effect at next frame
    live = cfgD;
    scen = "R8 mid-frame rewrite";
    startRun();
    stepRun(25);
    live = cfgB;
    stepRun(28 * 2 - 25 + 63 * 4 + 10);
    live = cfgA;
    stepRun(100);
    stepRun(63 * 4);
    stopRun();
    stepIdle(2);

    done = 1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

endmodule